// File: doc/BRIEF.md
# BIST Mask Arrangement Sequencer

This block decides, vector by vector, whether a built-in self-test session applies a pure pseudo-random vector or one customized by a mask, and which mask that is. The arrangement it picks sets the balance between cycle power and session length. Interleaving masks sparsely keeps switching per cycle low. Grouping them into consecutive blocks finishes the deterministic part early. The block holds no mask contents and makes no patterns. It only names a mask index, pulses an advance strobe to the pattern generator for every vector, and flags the end of the session.

Software or a test controller sets an arrangement mode, a mask count, a per-mask repetition count and a session length in vectors, then pulses start. Each session has pure pseudo-random vectors plus, for every mask, a group of vectors that mask customizes. Two arrangements exist. In interleaved mode (mode input 0), every group of three vectors is two unmasked vectors followed by one masked vector, and the mask index moves on with each group. In block mode (mode input 1), each mask is held for a run of consecutive vectors in ascending order, followed by an unmasked tail.

A three-state controller runs the session. The states are IDLE, RUN and FINISH. The transitions are:
- IDLE to RUN on an accepted start with a nonzero length.
- IDLE to FINISH on an accepted start with zero length.
- RUN to FINISH after the last vector.
- FINISH to IDLE unconditionally.

Top module: `bist_mask_seq`

## Requirements
- R1: After reset and while no session runs, `adv_o`, `done_o` and `mask_idx_o` are all 0.
- R2: A start pulse accepted at clock edge t makes `adv_o` high on exactly `len_i` consecutive cycles, beginning with the cycle that follows edge t.
- R3: `done_o` is high for exactly one cycle, directly after the last advance cycle. During that cycle `adv_o` and `mask_idx_o` are 0, and the next cycle is idle.
- R4: In interleaved mode with a nonzero mask count, vector k of the session (k counted from 0) is masked only when k mod 3 equals 2. All other vectors carry index 0.
- R5: In interleaved mode, masked vector k carries index ((k div 3) mod M) + 1, where M is the mask count. The index wraps from M back to 1 until the session ends.
- R6: In block mode with mask count M and repetition count P, both nonzero, vector k carries index (k div P) + 1 for every k below M·P. The indices therefore ascend from 1 to M, each held for P vectors.
- R7: In block mode, every vector from M·P onward carries index 0, as does every vector when P is 0.
- R8: A mask count of 0 gives index 0 on every vector in either mode.
- R9: A start pulse that arrives while a session runs has no effect. The running session keeps its vector count and its index sequence.
- R10: Mode, mask count, repetition count and length are sampled only when a start is accepted. Changing them during a session has no effect on that session.
- R11: A start with a length of 0 gives no advance cycle and gives `done_o` in the cycle right after the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Session start pulse, honoured only in IDLE |
| mode_i | input | 1 | Arrangement: 0 interleaved, 1 block |
| mask_cnt_i | input | IDX_W | Number of masks M |
| rep_cnt_i | input | REP_W | Vectors per mask in block mode, P |
| len_i | input | LEN_W | Session length in vectors |
| mask_idx_o | output | IDX_W | Mask index of the current vector, 0 for pure pseudo-random |
| adv_o | output | 1 | Pattern generator advance strobe, one per vector |
| done_o | output | 1 | One-cycle end-of-session flag |

## Verification
The bench sweeps every interleaved session with mask counts 0 to 4 and lengths 0, 1, 7 and 13. These runs separate the three-vector phase from the index wrap. It also sweeps block sessions over mask counts 0 to 3, repetition counts 0 to 3 and lengths 1, 5 and 12. Some of these lengths cut the session inside the mask blocks and others leave a pure tail, so an off-by-one in either the block boundary or the tail start shows up. Further runs inject a start pulse mid-session and scramble every configuration input. These runs tell a latched configuration apart from a live one.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

    typedef enum logic {
        ARR_INTERLEAVE = 1'b0,
        ARR_BLOCK      = 1'b1
    } arr_mode_t;

    // vectors per interleave group; the masked one is the last of the group
    localparam int unsigned GROUP_LEN = 3;

endpackage

// File: rtl/seq_vec_cnt.sv
module seq_vec_cnt #(
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             last_o
);

    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the top only consults this while running, where len_i is nonzero
    assign last_o = (cnt_q == len_i - 1'b1);

endmodule

// File: rtl/seq_mask_step.sv
module seq_mask_step
    import bist_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned REP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  arr_mode_t        mode_i,
    input  logic [IDX_W-1:0] mcnt_i,
    input  logic [REP_W-1:0] rep_i,
    output logic [IDX_W-1:0] mask_o
);

    localparam int unsigned SUB_W = (REP_W > 2) ? REP_W : 2;
    localparam logic [SUB_W-1:0] PHASE_MASKED = SUB_W'(GROUP_LEN - 1);

    logic [IDX_W-1:0] cur_q;
    logic [SUB_W-1:0] sub_q;
    logic             tail_q;
    logic [SUB_W-1:0] rep_last;
    logic             cur_is_last;

    assign rep_last    = SUB_W'(rep_i) - 1'b1;
    assign cur_is_last = (cur_q == mcnt_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            sub_q  <= '0;
            tail_q <= 1'b0;
        end else if (load_i) begin
            cur_q  <= IDX_W'(1);
            sub_q  <= '0;
            tail_q <= 1'b0;
        end else if (step_i) begin
            unique case (mode_i)
                ARR_INTERLEAVE: begin
                    if (sub_q == PHASE_MASKED) begin
                        sub_q <= '0;
                        cur_q <= cur_is_last ? IDX_W'(1) : cur_q + 1'b1;
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                ARR_BLOCK: begin
                    if (!tail_q) begin
                        if (sub_q == rep_last) begin
                            sub_q <= '0;
                            if (cur_is_last) begin
                                tail_q <= 1'b1;
                            end else begin
                                cur_q <= cur_q + 1'b1;
                            end
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                end
                default: begin
                    sub_q <= sub_q;
                end
            endcase
        end
    end

    always_comb begin
        mask_o = '0;
        if (mcnt_i != '0) begin
            unique case (mode_i)
                ARR_INTERLEAVE: mask_o = (sub_q == PHASE_MASKED) ? cur_q : '0;
                ARR_BLOCK:      mask_o = (tail_q || rep_i == '0) ? '0 : cur_q;
                default:        mask_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/bist_mask_seq.sv
module bist_mask_seq
    import bist_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned REP_W = 5,
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [IDX_W-1:0] mask_cnt_i,
    input  logic [REP_W-1:0] rep_cnt_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [IDX_W-1:0] mask_idx_o,
    output logic             adv_o,
    output logic             done_o
);

    seq_state_t       state_q, state_d;
    arr_mode_t        mode_q;
    logic [IDX_W-1:0] mcnt_q;
    logic [REP_W-1:0] rep_q;
    logic [LEN_W-1:0] len_q;
    logic             accept;
    logic             is_last;
    logic [IDX_W-1:0] step_mask;

    assign accept = (state_q == ST_IDLE) && start_i;

    // configuration is captured only on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= ARR_INTERLEAVE;
            mcnt_q <= '0;
            rep_q  <= '0;
            len_q  <= '0;
        end else if (accept) begin
            mode_q <= arr_mode_t'(mode_i);
            mcnt_q <= mask_cnt_i;
            rep_q  <= rep_cnt_i;
            len_q  <= len_i;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (len_i == '0) ? ST_FINISH : ST_RUN;
                end
            end
            ST_RUN: begin
                if (is_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        adv_o      = 1'b0;
        done_o     = 1'b0;
        mask_idx_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                adv_o = 1'b0;
            end
            ST_RUN: begin
                adv_o      = 1'b1;
                mask_idx_o = step_mask;
            end
            ST_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                adv_o = 1'b0;
            end
        endcase
    end

    seq_vec_cnt #(
        .LEN_W (LEN_W)
    ) u_vec_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (adv_o),
        .len_i  (len_q),
        .last_o (is_last)
    );

    seq_mask_step #(
        .IDX_W (IDX_W),
        .REP_W (REP_W)
    ) u_mask_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (adv_o),
        .mode_i (mode_q),
        .mcnt_i (mcnt_q),
        .rep_i  (rep_q),
        .mask_o (step_mask)
    );

endmodule

// File: rtl/bist_mask_seq_chk.sv
module bist_mask_seq_chk
    import bist_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             adv_o,
    input logic             done_o,
    input logic [IDX_W-1:0] mask_idx_o,
    input arr_mode_t        mode_q,
    input logic [IDX_W-1:0] mcnt_q
);

    // R3: the end flag never lasts two cycles
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: the cycle after the end flag is idle
    p_done_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!adv_o && mask_idx_o == '0));

    // R2: a run of advances only begins right after a start pulse
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adv_o) |-> $past(start_i));

    // R4: a masked interleaved vector is followed by an unmasked cycle
    p_interleave_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && mode_q == ARR_INTERLEAVE && mask_idx_o != '0) |=> (mask_idx_o == '0));

    // R5: the index never exceeds the captured mask count
    p_mask_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> (mask_idx_o <= mcnt_q));

    // R6: block indices never decrease within a session
    p_block_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && $past(adv_o) && mode_q == ARR_BLOCK && mask_idx_o != '0
         && $past(mask_idx_o) != '0) |-> (mask_idx_o >= $past(mask_idx_o)));

    // R7: once the block tail is reached it stays unmasked
    p_block_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && $past(adv_o) && mode_q == ARR_BLOCK && $past(mask_idx_o) == '0)
        |-> (mask_idx_o == '0));

endmodule

bind bist_mask_seq bist_mask_seq_chk #(
    .IDX_W (IDX_W)
) u_bist_mask_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .adv_o      (adv_o),
    .done_o     (done_o),
    .mask_idx_o (mask_idx_o),
    .mode_q     (mode_q),
    .mcnt_q     (mcnt_q)
);

// File: tb/test_bist_mask_seq.sv
`timescale 1ns/1ps
module test_bist_mask_seq;

    localparam int unsigned IDX_W = 4;
    localparam int unsigned REP_W = 5;
    localparam int unsigned LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             mode_i = 1'b0;
    logic [IDX_W-1:0] mask_cnt_i = '0;
    logic [REP_W-1:0] rep_cnt_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic [IDX_W-1:0] mask_idx_o;
    logic             adv_o;
    logic             done_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bist_mask_seq #(
        .IDX_W (IDX_W),
        .REP_W (REP_W),
        .LEN_W (LEN_W)
    ) i_bist_mask_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .mask_cnt_i (mask_cnt_i),
        .rep_cnt_i  (rep_cnt_i),
        .len_i      (len_i),
        .mask_idx_o (mask_idx_o),
        .adv_o      (adv_o),
        .done_o     (done_o)
    );

    task automatic chk(input int actual, input int expected, input string req, input string what);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    function automatic int exp_mask(input int mode, input int m, input int p, input int k);
        if (m == 0) return 0;
        if (mode == 0) return (k % 3 == 2) ? ((k / 3) % m) + 1 : 0;
        if (p == 0) return 0;
        return (k < m * p) ? (k / p) + 1 : 0;
    endfunction

    function automatic string mask_req(input int mode, input int m, input int p, input int k, input bit poke);
        if (poke && k >= 1) return "R9 R10";
        if (m == 0) return "R8";
        if (mode == 0) return (k % 3 == 2) ? "R5" : "R4";
        return (p != 0 && k < m * p) ? "R6" : "R7";
    endfunction

    task automatic run_session(input int mode, input int m, input int p, input int len, input bit poke);
        @(negedge clk);
        mode_i     = mode[0];
        mask_cnt_i = IDX_W'(m);
        rep_cnt_i  = REP_W'(p);
        len_i      = LEN_W'(len);
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < len; k++) begin
            chk(int'(adv_o), 1, "R2", "advance during session");
            chk(int'(done_o), 0, "R2", "no end flag mid-session");
            chk(int'(mask_idx_o), exp_mask(mode, m, p, k), mask_req(mode, m, p, k, poke), "mask index");
            if (poke && k == 1) begin
                // start mid-session plus scrambled configuration (R9, R10)
                start_i    = 1'b1;
                mode_i     = ~mode_i;
                mask_cnt_i = IDX_W'(m + 5);
                rep_cnt_i  = REP_W'(p + 3);
                len_i      = LEN_W'(2);
            end
            if (poke && k == 2) begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(int'(done_o), 1, (len == 0) ? "R11" : "R3", "end flag");
        chk(int'(adv_o), 0, "R3", "no advance with end flag");
        chk(int'(mask_idx_o), 0, "R3", "index zero with end flag");
        @(negedge clk);
        chk(int'(done_o), 0, "R3", "end flag single cycle");
        chk(int'(adv_o), 0, "R1", "idle after session");
        chk(int'(mask_idx_o), 0, "R1", "idle index");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(int'(adv_o), 0, "R1", "reset advance");
        chk(int'(done_o), 0, "R1", "reset end flag");
        chk(int'(mask_idx_o), 0, "R1", "reset index");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(adv_o), 0, "R1", "idle advance");

        // interleaved sweep (R4, R5, R8, R11)
        for (int m = 0; m <= 4; m++) begin
            run_session(0, m, 0, 0, 1'b0);
            run_session(0, m, 0, 1, 1'b0);
            run_session(0, m, 0, 7, 1'b0);
            run_session(0, m, 0, 13, 1'b0);
        end

        // block sweep (R6, R7, R8)
        for (int m = 0; m <= 3; m++) begin
            for (int p = 0; p <= 3; p++) begin
                run_session(1, m, p, 1, 1'b0);
                run_session(1, m, p, 5, 1'b0);
                run_session(1, m, p, 12, 1'b0);
            end
        end

        // start ignored and configuration latched (R9, R10)
        run_session(0, 3, 0, 14, 1'b1);
        run_session(1, 2, 3, 11, 1'b1);
        run_session(1, 3, 2, 6, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule